// File: doc/BRIEF.md
# Fault Confinement Error Counter Unit

This block tracks the health of a node on a shared, priority-arbitrated serial bus. It keeps two saturating counters, one for faults seen while the node is sending and one for faults seen while it is listening. Faults raise a counter quickly. Each clean transfer lowers the matching counter by one. A small state machine reads both counters and places the node in one of three health states. In the first state the node takes full part on the bus. In the second it goes quiet. In the third it is forbidden to drive the bus at all.

The error-detection logic elsewhere in the controller drives four single-cycle event pulses into the block: send fault, send success, receive fault and receive success. The transmitter and host read back the two counter values, a 2-bit state code and a transmit-permission flag. The state is held until a recovery pulse or a reset clears it. All outputs come from registers and take effect on the clock edge that samples the event.

Top module: `err_confine`

## Requirements
- R1: A send-fault pulse raises the transmit counter by 8 on the next clock edge. The sum saturates at 511 and never wraps.
- R2: A send-success pulse lowers the transmit counter by 1, and a receive-success pulse lowers the receive counter by 1. Neither counter goes below 0.
- R3: A receive-fault pulse raises the receive counter by 1. The counter saturates at 511 and never wraps.
- R4: `state_o` reads 2'b01 (quiet) whenever the transmit counter is in 128..255 or the receive counter is above 127. It reads 2'b00 (active) only when both counters are at or below 127, so the node returns to active once both have fallen to 127 or less.
- R5: When the transmit counter goes above 255, `state_o` becomes 2'b10 (disabled) and `tx_allow_o` goes low. In any other state `tx_allow_o` is high.
- R6: The receive counter alone never puts the node in the disabled state, even when it is saturated at 511.
- R7: In the disabled state, all four event pulses are ignored: both counters and the state hold their values.
- R8: A reset or a `recover_i` pulse clears both counters to 0 and sets `state_o` to 2'b00. `recover_i` overrides any event pulse in the same cycle.
- R9: If a fault and a success for the same counter arrive in the same cycle, only the fault step is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recover_i | input | 1 | Synchronous clear of both counters and the state |
| tx_err_i | input | 1 | Fault detected while sending (one-cycle pulse) |
| tx_ok_i | input | 1 | Frame sent without fault (one-cycle pulse) |
| rx_err_i | input | 1 | Fault detected while receiving (one-cycle pulse) |
| rx_ok_i | input | 1 | Frame received without fault (one-cycle pulse) |
| tx_cnt_o | output | 9 | Transmit error counter |
| rx_cnt_o | output | 9 | Receive error counter |
| state_o | output | 2 | 00 active, 01 quiet, 10 disabled |
| tx_allow_o | output | 1 | High when the node may drive the bus |

## Verification
The bench uses the default parameters: 9-bit counters, steps of 8 and 1, and limits of 127 and 255. With these values the quiet state takes 16 send faults to reach and the disabled state takes 32, so both thresholds come up often in random traffic. Saturating the receive counter at 511 takes only about 511 cycles, which lets the bench check that a full receive counter leaves the node quiet and not disabled. Random events with an occasional recovery pulse cross the thresholds in both directions, including exits from the quiet state that depend on both counters together.

// File: rtl/err_confine_pkg.sv
`timescale 1ns/1ps
package err_confine_pkg;

    // Health state encoding; the values are seen at the state_o port.
    typedef enum logic [1:0] {
        HS_ACTIVE   = 2'b00,
        HS_QUIET    = 2'b01,
        HS_DISABLED = 2'b10
    } health_e;

    localparam int unsigned DEF_CNT_W       = 9;
    localparam int unsigned DEF_TX_UP       = 8;
    localparam int unsigned DEF_RX_UP       = 1;
    localparam int unsigned DEF_DOWN        = 1;
    localparam int unsigned DEF_QUIET_LIM   = 127;
    localparam int unsigned DEF_DISABLE_LIM = 255;

endpackage

// File: rtl/err_sat_counter.sv
`timescale 1ns/1ps
// Saturating up/down counter. A fault step wins over a success step;
// hold freezes the value; clear has priority over everything.
module err_sat_counter #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned UP    = 8,
    parameter int unsigned DOWN  = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             hold_i,
    input  logic             up_i,
    input  logic             down_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] cnt_q_o
);

    localparam logic [CNT_W:0]   MAX_W   = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0]   UP_W    = (CNT_W+1)'(UP);
    localparam logic [CNT_W-1:0] DOWN_V  = CNT_W'(DOWN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic [CNT_W:0] sum_w;

    always_comb begin
        st_d  = st_q;
        sum_w = {1'b0, st_q.cnt} + UP_W;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (!hold_i) begin
            if (up_i) begin
                if (sum_w > MAX_W) begin
                    st_d.cnt = MAX_W[CNT_W-1:0];
                end else begin
                    st_d.cnt = sum_w[CNT_W-1:0];
                end
            end else if (down_i) begin
                if (st_q.cnt >= DOWN_V) begin
                    st_d.cnt = st_q.cnt - DOWN_V;
                end else begin
                    st_d.cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_d_o = st_d.cnt;
    assign cnt_q_o = st_q.cnt;

endmodule

// File: rtl/err_health_fsm.sv
`timescale 1ns/1ps
// Three-state health machine driven by the next counter values.
module err_health_fsm
    import err_confine_pkg::*;
#(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned QUIET_LIM   = 127,
    parameter int unsigned DISABLE_LIM = 255
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] tx_next_i,
    input  logic [CNT_W-1:0] rx_next_i,
    output health_e          state_o,
    output logic             disabled_o
);

    localparam logic [CNT_W-1:0] QLIM = CNT_W'(QUIET_LIM);
    localparam logic [CNT_W-1:0] DLIM = CNT_W'(DISABLE_LIM);

    typedef struct packed {
        health_e hs;
    } fsm_state_t;

    fsm_state_t st_q, st_d;
    logic tx_over_d, tx_warn_d, rx_warn_d;

    always_comb begin
        st_d      = st_q;
        tx_over_d = (tx_next_i > DLIM);
        tx_warn_d = (tx_next_i > QLIM);
        rx_warn_d = (rx_next_i > QLIM);
        if (clr_i) begin
            st_d.hs = HS_ACTIVE;
        end else begin
            unique case (st_q.hs)
                HS_DISABLED: st_d.hs = HS_DISABLED;
                HS_ACTIVE, HS_QUIET: begin
                    if (tx_over_d) begin
                        st_d.hs = HS_DISABLED;
                    end else if (tx_warn_d || rx_warn_d) begin
                        st_d.hs = HS_QUIET;
                    end else begin
                        st_d.hs = HS_ACTIVE;
                    end
                end
                default: st_d.hs = HS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{hs: HS_ACTIVE};
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o    = st_q.hs;
    assign disabled_o = (st_q.hs == HS_DISABLED);

endmodule

// File: rtl/err_confine.sv
`timescale 1ns/1ps
module err_confine
    import err_confine_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned TX_UP       = DEF_TX_UP,
    parameter int unsigned RX_UP       = DEF_RX_UP,
    parameter int unsigned DOWN        = DEF_DOWN,
    parameter int unsigned QUIET_LIM   = DEF_QUIET_LIM,
    parameter int unsigned DISABLE_LIM = DEF_DISABLE_LIM
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             recover_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [CNT_W-1:0] rx_cnt_o,
    output logic [1:0]       state_o,
    output logic             tx_allow_o
);

    localparam int unsigned NCNT = 2;

    logic [NCNT-1:0]            up_w, down_w;
    logic [NCNT-1:0][CNT_W-1:0] nxt_w, cur_w;
    logic                       disabled_w;
    health_e                    hs_w;

    assign up_w   = {rx_err_i, tx_err_i};
    assign down_w = {rx_ok_i,  tx_ok_i};

    // Index 0 counts send faults, index 1 counts receive faults.
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        localparam int unsigned STEP = (g == 0) ? TX_UP : RX_UP;
        err_sat_counter #(
            .CNT_W (CNT_W),
            .UP    (STEP),
            .DOWN  (DOWN)
        ) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (recover_i),
            .hold_i  (disabled_w),
            .up_i    (up_w[g]),
            .down_i  (down_w[g]),
            .cnt_d_o (nxt_w[g]),
            .cnt_q_o (cur_w[g])
        );
    end

    err_health_fsm #(
        .CNT_W       (CNT_W),
        .QUIET_LIM   (QUIET_LIM),
        .DISABLE_LIM (DISABLE_LIM)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (recover_i),
        .tx_next_i  (nxt_w[0]),
        .rx_next_i  (nxt_w[1]),
        .state_o    (hs_w),
        .disabled_o (disabled_w)
    );

    assign tx_cnt_o   = cur_w[0];
    assign rx_cnt_o   = cur_w[1];
    assign state_o    = hs_w;
    assign tx_allow_o = !disabled_w;

endmodule

// File: rtl/err_confine_chk.sv
`timescale 1ns/1ps
module err_confine_chk #(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned TX_UP       = 8,
    parameter int unsigned QUIET_LIM   = 127,
    parameter int unsigned DISABLE_LIM = 255
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             recover_i,
    input logic             tx_err_i,
    input logic             tx_ok_i,
    input logic             rx_err_i,
    input logic             rx_ok_i,
    input logic [CNT_W-1:0] tx_cnt_o,
    input logic [CNT_W-1:0] rx_cnt_o,
    input logic [1:0]       state_o,
    input logic             tx_allow_o
);

    localparam logic [CNT_W-1:0] STEP  = CNT_W'(TX_UP);
    localparam logic [CNT_W-1:0] ROOM  = CNT_W'((1 << CNT_W) - 1 - TX_UP);
    localparam logic [CNT_W-1:0] QLIM  = CNT_W'(QUIET_LIM);
    localparam logic [CNT_W-1:0] DLIM  = CNT_W'(DISABLE_LIM);

    // R1: send fault adds the step when there is room
    p_tx_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_err_i && !recover_i && state_o != 2'b10 && tx_cnt_o <= ROOM)
        |=> (tx_cnt_o == $past(tx_cnt_o) + STEP));

    // R2: a lone success at zero leaves the counter at zero
    p_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_ok_i && !tx_err_i && !recover_i && tx_cnt_o == '0) |=> (tx_cnt_o == '0));

    // R4: active implies both counters at or below the quiet limit
    p_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b00) |-> (tx_cnt_o <= QLIM && rx_cnt_o <= QLIM));

    // R4: quiet implies one counter above the limit and transmit not over
    p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b01) |-> ((tx_cnt_o > QLIM || rx_cnt_o > QLIM) && tx_cnt_o <= DLIM));

    // R5, R6: disabled only with the transmit counter over its limit
    p_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b10) |-> (tx_cnt_o > DLIM && !tx_allow_o));

    // R7: disabled state freezes everything until recovery
    p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b10 && !recover_i)
        |=> ($stable(tx_cnt_o) && $stable(rx_cnt_o) && state_o == 2'b10));

    // R8: recovery clears counters and state
    p_recover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recover_i |=> (tx_cnt_o == '0 && rx_cnt_o == '0 && state_o == 2'b00));

    // R4: state code is always a legal value
    p_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'b11);

    // R9: fault and success together never lower the counter
    p_err_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_err_i && rx_ok_i && !recover_i && state_o != 2'b10)
        |=> (rx_cnt_o >= $past(rx_cnt_o)));

endmodule

bind err_confine err_confine_chk #(
    .CNT_W       (CNT_W),
    .TX_UP       (TX_UP),
    .QUIET_LIM   (QUIET_LIM),
    .DISABLE_LIM (DISABLE_LIM)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .recover_i  (recover_i),
    .tx_err_i   (tx_err_i),
    .tx_ok_i    (tx_ok_i),
    .rx_err_i   (rx_err_i),
    .rx_ok_i    (rx_ok_i),
    .tx_cnt_o   (tx_cnt_o),
    .rx_cnt_o   (rx_cnt_o),
    .state_o    (state_o),
    .tx_allow_o (tx_allow_o)
);

// File: tb/err_confine_test.sv
`timescale 1ns/1ps
module err_confine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rc = 0, te = 0, to = 0, re = 0, ro = 0;
    logic [8:0] tx_cnt, rx_cnt;
    logic [1:0] st;
    logic       allow;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_tx = 0, m_rx = 0, m_st = 0;

    always #4 clk = ~clk;

    err_confine uut (
        .clk_i(clk), .rst_ni(rst_n), .recover_i(rc),
        .tx_err_i(te), .tx_ok_i(to), .rx_err_i(re), .rx_ok_i(ro),
        .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .state_o(st), .tx_allow_o(allow)
    );

    function automatic int up_sat(int v, int s);
        return (v + s > 511) ? 511 : v + s;
    endfunction

    function automatic int dn_sat(int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic model(bit c, bit a, bit b, bit d, bit e);
        if (c) begin
            m_tx = 0; m_rx = 0; m_st = 0;
        end else if (m_st != 2) begin
            if (a) m_tx = up_sat(m_tx, 8); else if (b) m_tx = dn_sat(m_tx);
            if (d) m_rx = up_sat(m_rx, 1); else if (e) m_rx = dn_sat(m_rx);
            if (m_tx > 255) m_st = 2;
            else if (m_tx > 127 || m_rx > 127) m_st = 1;
            else m_st = 0;
        end
    endtask

    task automatic check(string tag);
        total++;
        if (tx_cnt !== 9'(m_tx) || rx_cnt !== 9'(m_rx) || st !== 2'(m_st)
            || allow !== (m_st != 2)) begin
            bad++;
            $display("FAIL %s: got tx=%0d rx=%0d st=%0d allow=%0d exp tx=%0d rx=%0d st=%0d allow=%0d",
                     tag, tx_cnt, rx_cnt, st, allow, m_tx, m_rx, m_st, m_st != 2);
        end
    endtask

    // Apply one cycle of events, then check just after the sampling edge.
    task automatic step(bit c, bit a, bit b, bit d, bit e, string tag);
        @(negedge clk);
        rc = c; te = a; to = b; re = d; ro = e;
        model(c, a, b, d, e);
        @(posedge clk);
        #2;
        check(tag);
        rc = 0; te = 0; to = 0; re = 0; ro = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset");
        rst_n = 1'b1;

        // R1, R4: sixteen send faults reach the quiet state at 128
        for (int i = 0; i < 16; i++) step(0, 1, 0, 0, 0, "R1 R4 tx climb");
        // R9: fault and success together -> 136
        step(0, 1, 1, 0, 0, "R9 tx fault beats success");
        // R2, R4: nine successes bring 136 to 127 and back to active
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, "R2 R4 tx descend");
        // R4: receive counter pushes node quiet while tx is 127
        for (int i = 0; i < 128; i++) step(0, 0, 0, 1, 0, "R3 R4 rx climb");
        step(0, 0, 0, 1, 1, "R9 rx fault beats success");
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 1, "R4 rx descend to 127");
        step(0, 0, 0, 0, 0, "R4 idle hold");
        // R8: recovery clears everything
        step(1, 0, 0, 0, 0, "R8 recover");
        // R2: success at zero stays at zero
        step(0, 0, 1, 0, 1, "R2 floor at zero");
        // R3, R6: receive counter saturates, node stays quiet
        for (int i = 0; i < 520; i++) step(0, 0, 0, 1, 0, "R3 R6 rx saturate");
        step(1, 0, 0, 0, 0, "R8 recover");
        // R5: thirty-two send faults -> 256, disabled
        for (int i = 0; i < 32; i++) step(0, 1, 0, 0, 0, "R5 tx to disabled");
        // R7: events ignored while disabled
        step(0, 1, 0, 1, 0, "R7 faults ignored");
        step(0, 0, 1, 0, 1, "R7 successes ignored");
        step(0, 1, 1, 1, 1, "R7 all ignored");
        // R8: recovery beats a simultaneous fault
        step(1, 1, 0, 1, 0, "R8 recover over fault");

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            bit c = ($urandom_range(0, 199) == 0);
            bit a = ($urandom_range(0, 3) == 0);
            bit b = ($urandom_range(0, 2) == 0);
            bit d = ($urandom_range(0, 2) == 0);
            bit e = ($urandom_range(0, 2) == 0);
            step(c, a, b, d, e, "rand R1 R2 R3 R4 R5 R7 R8 R9");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule